// File: doc/BRIEF.md
# Integer Execute Unit with Product/Quotient Registers

This block is the execute stage of a single-cycle integer core. Each cycle it receives an operation code and two 32-bit operands. Operand B may carry a register value, an extended immediate or a shift distance. The block returns a combinational result together with a zero flag and a signed-overflow flag. The surrounding core halts when the overflow flag rises. The same zero flag drives the core's conditional branches:

- Equality tests run as a subtraction.
- Sign tests run as a set-less-than against a zero operand, with the operand order picked per branch.

Multiply and divide do not drive the result bus. They write a double-width outcome into two internal registers, the upper register (UPR) and the lower register (LWR). These registers load on the rising clock edge of the multiply or divide cycle. Two read-back operations return them through the result port.

Top module: `exu_core`

## Requirements
- R1: Operation codes are ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, XOR=6, NOR=7, SLT=8, SLTU=9, SLL=10, SRL=11, SRA=12, MULT=13, MULTU=14, DIV=15, DIVU=16, RDUP=17, RDLO=18. Add and subtract return A+B and A-B modulo 2^32, the logic codes return the bitwise result of A and B, and codes 13 to 16 and 19 to 31 return 0 on the result port.
- R2: The zero flag is 1 exactly when the result port equals 0, for every operation code.
- R3: The overflow flag rises only for ADD and SUB when the signed result does not fit in 32 bits. It stays 0 for every other code, including ADDU, SUBU, multiply and divide.
- R4: SLT returns 1 when A is less than B as signed numbers and 0 otherwise. SLTU makes the same comparison as unsigned numbers.
- R5: The shifts move A by the amount held in B[4:0] and ignore the upper bits of B. SLL and SRL fill with zeros; SRA fills with the sign bit of A.
- R6: MULT (both operands sign-extended) and MULTU (both zero-extended) form a 64-bit product. At the clock edge closing that cycle, the low 32 bits go to LWR and the high 32 bits go to UPR.
- R7: DIV and DIVU write the quotient to LWR and the remainder to UPR. Signed division truncates toward zero and the remainder takes the dividend's sign. The case -2^31 / -1 writes LWR=0x80000000 and UPR=0.
- R8: A DIV or DIVU with B equal to 0 leaves UPR and LWR unchanged and raises no flag.
- R9: RDUP returns UPR and RDLO returns LWR. Both registers reset to 0 and change only on a multiply or a divide with a non-zero divisor.
- R10: As a branch comparison, SUB gives zero flag 1 exactly when A equals B. SLT with one operand tied to 0 gives the sign test needed by the greater/less-than-zero branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; UPR/LWR load on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of UPR/LWR |
| op_i | input | 5 | Operation code (see R1) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (register, immediate or shift amount) |
| res_o | output | 32 | Combinational result |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Signed overflow of ADD/SUB |

## Verification
A multiply or divide cycle does two things at once. The flags come from a forced-zero result within the cycle, and UPR/LWR load at the closing edge. The bench checks in that cycle that the result is 0, the zero flag is 1 and overflow is 0. It then issues RDUP/RDLO in the following cycle and compares them with a model product or quotient. Random streams mix overflowing adds next to reads of UPR/LWR, and zero divisors right after multiplies. This shows that the held value survives, and that overflow never leaks into the register path or back out of it.

// File: rtl/exu_pkg.sv
package exu_pkg;
   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
      OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7,
      OP_SLT   = 5'd8,  OP_SLTU  = 5'd9,  OP_SLL  = 5'd10, OP_SRL  = 5'd11,
      OP_SRA   = 5'd12, OP_MULT  = 5'd13, OP_MULTU = 5'd14,
      OP_DIV   = 5'd15, OP_DIVU  = 5'd16, OP_RDUP = 5'd17, OP_RDLO = 5'd18
   } exu_op_e;

   typedef enum logic [1:0] {SH_LL = 2'd0, SH_RL = 2'd1, SH_RA = 2'd2} exu_sh_e;

   function automatic logic is_muldiv(input logic [4:0] op);
      return (op >= 5'd13) && (op <= 5'd16);
   endfunction
endpackage

// File: rtl/exu_addsub.sv
module exu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         sovf_o
);
   logic [W-1:0] b_eff;
   always_comb begin
      b_eff  = sub_i ? ~b_i : b_i;
      sum_o  = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
      // signed overflow: operands of like sign give a result of other sign
      sovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
   end
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(W)
) (
   input  logic [W-1:0]   a_i,
   input  logic [SHW-1:0] amt_i,
   input  logic [1:0]     kind_i,
   output logic [W-1:0]   res_o
);
   import exu_pkg::*;

   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] stage [SHW+1];
         logic         fill;
         assign fill     = (kind_i == SH_RA) ? a_i[W-1] : 1'b0;
         assign stage[0] = a_i;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            always_comb begin
               if (!amt_i[s])
                  stage[s+1] = stage[s];
               else if (kind_i == SH_LL)
                  stage[s+1] = {stage[s][W-D-1:0], {D{1'b0}}};
               else
                  stage[s+1] = {{D{fill}}, stage[s][W-1:D]};
            end
         end
         assign res_o = stage[SHW];
      end else begin : g_operator
         always_comb begin
            case (kind_i)
               SH_LL:   res_o = a_i << amt_i;
               SH_RA:   res_o = $unsigned($signed(a_i) >>> amt_i);
               default: res_o = a_i >> amt_i;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/exu_muldiv.sv
module exu_muldiv #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [4:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] upr_o,
   output logic [W-1:0] lwr_o
);
   import exu_pkg::*;
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic [2*W-1:0] prod;
   logic [W-1:0]   quo, rem;
   logic           load;

   always_comb begin
      prod = '0;
      quo  = '0;
      rem  = '0;
      load = 1'b0;
      case (op_i)
         OP_MULT: begin
            prod = {{W{a_i[W-1]}}, a_i} * {{W{b_i[W-1]}}, b_i};
            load = 1'b1;
         end
         OP_MULTU: begin
            prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
            load = 1'b1;
         end
         OP_DIV: if (b_i != '0) begin
            load = 1'b1;
            if (a_i == SMIN && b_i == '1) begin
               quo = SMIN;
               rem = '0;
            end else begin
               quo = $unsigned($signed(a_i) / $signed(b_i));
               rem = $unsigned($signed(a_i) % $signed(b_i));
            end
            prod = {rem, quo};
         end
         OP_DIVU: if (b_i != '0) begin
            load = 1'b1;
            quo  = a_i / b_i;
            rem  = a_i % b_i;
            prod = {rem, quo};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upr_o <= '0;
         lwr_o <= '0;
      end else if (load) begin
         upr_o <= prod[2*W-1:W];
         lwr_o <= prod[W-1:0];
      end
   end
endmodule

// File: rtl/exu_core.sv
module exu_core #(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [4:0]   op_i,
   input  logic [31:0]  a_i,
   input  logic [31:0]  b_i,
   output logic [31:0]  res_o,
   output logic         zero_o,
   output logic         ovf_o
);
   import exu_pkg::*;
   localparam int SHW = $clog2(W);

   generate
      if (W != 32) begin : g_bad_width
         $error("exu_core: ports are fixed at 32 bits, W must be 32");
      end
      if ((1 << SHW) != W) begin : g_bad_pow2
         $error("exu_core: W must be a power of two");
      end
   endgenerate

   logic [W-1:0] as_sum, upr_w, lwr_w, sh_res;
   logic         as_ovf, as_sub;
   logic [1:0]   sh_kind;
   exu_op_e      op;

   assign op      = exu_op_e'(op_i);
   assign as_sub  = (op == OP_SUB) || (op == OP_SUBU);
   assign sh_kind = (op == OP_SLL) ? SH_LL : (op == OP_SRA) ? SH_RA : SH_RL;

   exu_addsub #(.W(W)) u_addsub (
      .a_i(a_i), .b_i(b_i), .sub_i(as_sub), .sum_o(as_sum), .sovf_o(as_ovf)
   );

   exu_shift #(.W(W), .BARREL(BARREL)) u_shift (
      .a_i(a_i), .amt_i(b_i[SHW-1:0]), .kind_i(sh_kind), .res_o(sh_res)
   );

   exu_muldiv #(.W(W)) u_muldiv (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .upr_o(upr_w), .lwr_o(lwr_w)
   );

   always_comb begin
      res_o = '0;
      ovf_o = 1'b0;
      case (op)
         OP_ADD, OP_SUB: begin
            res_o = as_sum;
            ovf_o = as_ovf;
         end
         OP_ADDU, OP_SUBU: res_o = as_sum;
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_NOR:  res_o = ~(a_i | b_i);
         OP_SLT:  res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
         OP_SLTU: res_o = {{(W-1){1'b0}}, (a_i < b_i)};
         OP_SLL, OP_SRL, OP_SRA: res_o = sh_res;
         OP_RDUP: res_o = upr_w;
         OP_RDLO: res_o = lwr_w;
         default: ;
      endcase
   end

   assign zero_o = (res_o == '0);
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [4:0]   op_i,
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic [W-1:0] res_o,
   input logic         ovf_o,
   input logic [W-1:0] upr_q,
   input logic [W-1:0] lwr_q
);
   import exu_pkg::*;

   // R9: registers hold across every non-multiply/divide code
   a_r9_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
      !is_muldiv(op_i) |=> ($stable(upr_q) && $stable(lwr_q)));

   // R8: zero divisor leaves both registers untouched
   a_r8_divzero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == OP_DIV || op_i == OP_DIVU) && b_i == '0)
      |=> ($stable(upr_q) && $stable(lwr_q)));

   // R3: only ADD and SUB may raise overflow
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i != OP_ADD && op_i != OP_SUB) |-> !ovf_o);

   // R9: read-back codes return the held registers
   a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == OP_RDUP) |-> (res_o == upr_q)) and ((op_i == OP_RDLO) |-> (res_o == lwr_q)));

   // R6: low product half lands in the lower register
   a_r6_mul_low: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_MULT || op_i == OP_MULTU)
      |=> (lwr_q == W'($past(a_i) * $past(b_i))));

   // R1: multiply and divide codes drive 0 on the result port
   a_r1_md_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      is_muldiv(op_i) |-> (res_o == '0));
endmodule

bind exu_core exu_core_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
   .res_o(res_o), .ovf_o(ovf_o), .upr_q(upr_w), .lwr_q(lwr_w)
);

// File: tb/exu_core_bench.sv
module exu_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op = 5'd0;
   logic [31:0] a = '0, b = '0;
   logic [31:0] res;
   logic        zero, ovf;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] m_upr = '0, m_lwr = '0;

   always #5 clk = ~clk;

   exu_core u_exu_core (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .res_o(res), .zero_o(zero), .ovf_o(ovf)
   );

   function automatic string tag_of(input logic [4:0] o);
      if (o <= 5'd7) return "R1";
      if (o <= 5'd9) return "R4";
      if (o <= 5'd12) return "R5";
      if (o <= 5'd14) return "R6";
      if (o <= 5'd16) return "R7";
      if (o <= 5'd18) return "R9";
      return "R1";
   endfunction

   function automatic logic [31:0] exp_res(input logic [4:0] o, input logic [31:0] x, y);
      case (o)
         5'd0, 5'd1: return x + y;
         5'd2, 5'd3: return x - y;
         5'd4:  return x & y;
         5'd5:  return x | y;
         5'd6:  return x ^ y;
         5'd7:  return ~(x | y);
         5'd8:  return (int'(x) < int'(y)) ? 32'd1 : 32'd0;
         5'd9:  return (x < y) ? 32'd1 : 32'd0;
         5'd10: return x << y[4:0];
         5'd11: return x >> y[4:0];
         5'd12: return 32'(int'(x) >>> y[4:0]);
         5'd17: return m_upr;
         5'd18: return m_lwr;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic exp_ovf(input logic [4:0] o, input logic [31:0] x, y);
      logic [32:0] w;
      if (o == 5'd0) w = {x[31], x} + {y[31], y};
      else if (o == 5'd2) w = {x[31], x} - {y[31], y};
      else return 1'b0;
      return w[32] != w[31];
   endfunction

   task automatic model_update(input logic [4:0] o, input logic [31:0] x, y);
      longint p;
      logic [63:0] pu;
      case (o)
         5'd13: begin p = longint'(int'(x)) * longint'(int'(y)); m_upr = p[63:32]; m_lwr = p[31:0]; end
         5'd14: begin pu = {32'd0, x} * {32'd0, y}; m_upr = pu[63:32]; m_lwr = pu[31:0]; end
         5'd15: if (y != 0) begin
            if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) begin m_lwr = x; m_upr = 0; end
            else begin m_lwr = 32'(int'(x) / int'(y)); m_upr = 32'(int'(x) % int'(y)); end
         end
         5'd16: if (y != 0) begin m_lwr = x / y; m_upr = x % y; end
         default: ;
      endcase
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] got, exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   // drive at negedge, check combinational outputs, let the edge update the model
   task automatic run(input logic [4:0] o, input logic [31:0] x, y);
      logic [31:0] e;
      @(negedge clk);
      op = o; a = x; b = y;
      #2;
      e = exp_res(o, x, y);
      chk(tag_of(o), $sformatf("result op=%0d", o), res, e);
      chk("R2", "zero flag", {31'd0, zero}, {31'd0, e == 0});
      chk("R3", "overflow", {31'd0, ovf}, {31'd0, exp_ovf(o, x, y)});
      @(posedge clk);
      model_update(o, x, y);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [31:0] x, y;
      logic [4:0]  o;
      void'($urandom(32'd20240611));
      // R9: reset state
      op = 5'd17;
      repeat (2) @(posedge clk);
      #2;
      chk("R9", "UPR at reset", res, 32'd0);
      chk("R2", "zero at reset", {31'd0, zero}, 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      run(5'd18, 0, 0);

      // directed corners
      run(5'd0, 32'h7FFF_FFFF, 32'd1);          // R3 add overflow
      run(5'd1, 32'h7FFF_FFFF, 32'd1);          // R3 ADDU quiet
      run(5'd2, 32'h8000_0000, 32'd1);          // R3 sub overflow
      run(5'd3, 32'h8000_0000, 32'd1);
      run(5'd2, 32'd77, 32'd77);                // R10 equal -> zero
      run(5'd2, 32'd77, 32'd78);                // R10 not equal
      run(5'd8, 32'hFFFF_FFF0, 32'd0);          // R10 rs<0
      run(5'd8, 32'd0, 32'd5);                  // R10 0<rs
      run(5'd9, 32'hFFFF_FFF0, 32'd0);          // R4 unsigned
      run(5'd12, 32'h8000_0010, 32'hFFFF_FFE4); // R5 upper B bits ignored
      run(5'd10, 32'h0000_0003, 32'h0000_0120);
      run(5'd13, 32'hFFFF_FFFF, 32'd2);         // R6 signed
      run(5'd17, 0, 0); run(5'd18, 0, 0);
      run(5'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R6 unsigned
      run(5'd15, 32'd7, 32'd0);                 // R8 divide by zero
      run(5'd17, 0, 0); run(5'd18, 0, 0);
      run(5'd16, 32'd7, 32'd0);                 // R8
      run(5'd17, 0, 0); run(5'd18, 0, 0);
      run(5'd15, 32'hFFFF_FFF9, 32'd2);         // R7 -7/2 -> -3 r -1
      run(5'd17, 0, 0); run(5'd18, 0, 0);
      run(5'd15, 32'h8000_0000, 32'hFFFF_FFFF); // R7 min/-1
      run(5'd17, 0, 0); run(5'd18, 0, 0);
      run(5'd20, 32'd5, 32'd6);                 // R1 unused code
      run(5'd17, 0, 0);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         o = 5'($urandom_range(0, 20));
         x = $urandom();
         y = $urandom();
         case ($urandom_range(0, 7))
            0: y = 0;
            1: y = 32'($urandom_range(0, 40));
            2: x = 32'h8000_0000;
            3: y = x;
            default: ;
         endcase
         run(o, x, y);
         if ($urandom_range(0, 3) == 0) run(5'($urandom_range(17, 18)), 0, 0);
      end
      done = 1;
      summary();
   end
endmodule